// File: doc/BRIEF.md
# Aliased Multi-Width Integer Register File

This block holds sixteen 64-bit integer registers with two read ports and one write port. Each port picks a register and an operand size. The 32-bit, 16-bit and byte views are windows onto the low part of the same 64-bit storage, so there is no separate storage for them. A port names a register with a 3-bit base field and an extension bit. The extension bit counts only when the instruction carried a prefix. Registers 8 to 15 can be reached only that way.

The byte view changes meaning with the prefix. With no prefix, base codes 4 to 7 select bits 15:8 of registers 0 to 3. With a prefix, every base code selects the low byte of the named register. A 64-bit program counter sits beside the file and has its own 32-bit low view. The decode stage drives the ports directly. Reads are combinational and writes take effect at the clock edge.

Top module: `aliased_regfile`

## Requirements
- R1: While `rst_n` is low, all sixteen registers clear to zero and the program counter loads the `RESET_VEC` parameter.
- R2: The register number is {ext, base} when `pfx` is 1. When `pfx` is 0 the `ext` bit is ignored and the number is {0, base}.
- R3: The size codes are 0 = 64-bit, 1 = 32-bit, 2 = 16-bit and 3 = byte. A read returns the selected view zero-extended to 64 bits.
- R4: A 32-bit write stores the low 32 data bits and clears bits 63:32 of the target.
- R5: A 16-bit write changes only bits 15:8 and 7:0 of the target. A byte write changes only its one byte. All other bits keep their values.
- R6: For a byte access with `pfx` = 0, base 0 to 3 selects bits 7:0 of register base, and base 4 to 7 selects bits 15:8 of register base-4.
- R7: For a byte access with `pfx` = 1, any base selects bits 7:0 of register {ext, base}.
- R8: Read data follows the current register contents combinationally. A write is visible only after the next rising edge. A read of the register being written in the same cycle returns the old value.
- R9: Both read ports operate independently and at the same time, each with its own register number and size.
- R10: With `pc_we` = 1 the program counter loads `pc_next`, and also clears bits 63:32 when `pc_narrow` = 1. With `pc_we` = 0 it holds its value. `pc_lo` always equals bits 31:0 of `pc_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_base | input | 3 | Read port 0 base register field |
| rd0_ext | input | 1 | Read port 0 extension bit |
| rd0_pfx | input | 1 | Read port 0 prefix present |
| rd0_size | input | 2 | Read port 0 operand size code |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd1_base | input | 3 | Read port 1 base register field |
| rd1_ext | input | 1 | Read port 1 extension bit |
| rd1_pfx | input | 1 | Read port 1 prefix present |
| rd1_size | input | 2 | Read port 1 operand size code |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_base | input | 3 | Write base register field |
| wr_ext | input | 1 | Write extension bit |
| wr_pfx | input | 1 | Write prefix present |
| wr_size | input | 2 | Write operand size code |
| wr_data | input | 64 | Write data (low bits used for narrow sizes) |
| pc_we | input | 1 | Program counter load enable |
| pc_narrow | input | 1 | Program counter load is 32-bit, zero-extending |
| pc_next | input | 64 | Program counter load value |
| pc_q | output | 64 | Program counter value |
| pc_lo | output | 32 | Low 32-bit view of the program counter |

## Verification
The assertions check four things on every cycle. A write hits exactly one register, and registers that are not hit keep their value. A 32-bit write clears the upper half, and a narrow write keeps bits 63:16. Narrow reads come back zero-extended on both ports, and the program counter holds and zero-extends as specified. Other behaviours need the bench's scenarios against its reference model: the routing of the high byte to registers 0 to 3, the change of byte meaning when the prefix is set, the ext bit being ignored without a prefix, and old-value reads during a same-cycle write.

// File: rtl/arf_pkg.sv
`timescale 1ns/1ps
package arf_pkg;
  localparam int XLEN   = 64;
  localparam int BASE_W = 3;
  localparam int IDX_W  = BASE_W + 1;
  localparam int NREG   = 1 << IDX_W;
  localparam int DW_W   = XLEN / 2;
  localparam int WD_W   = 16;
  localparam int BY_W   = 8;
  localparam int NRD    = 2;

  typedef enum logic [1:0] {
    SZ_QUAD  = 2'd0,
    SZ_DWORD = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_BYTE  = 2'd3
  } opsize_e;

  typedef enum logic [2:0] {
    LN_Q  = 3'd0,
    LN_D  = 3'd1,
    LN_W  = 3'd2,
    LN_BL = 3'd3,
    LN_BH = 3'd4
  } lane_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    lane_e            lane;
  } operand_t;

  // Turns an instruction's register fields into a storage index and a lane.
  function automatic operand_t decode_operand(
    input logic [BASE_W-1:0] base,
    input logic              ext,
    input logic              pfx,
    input logic [1:0]        size
  );
    operand_t o;
    o.idx = {pfx & ext, base};
    case (opsize_e'(size))
      SZ_QUAD:  o.lane = LN_Q;
      SZ_DWORD: o.lane = LN_D;
      SZ_WORD:  o.lane = LN_W;
      default: begin
        if (!pfx && base[BASE_W-1]) begin
          o.idx  = {{(IDX_W-BASE_W+1){1'b0}}, base[BASE_W-2:0]};
          o.lane = LN_BH;
        end else begin
          o.lane = LN_BL;
        end
      end
    endcase
    return o;
  endfunction

  // New register contents after a write through the given lane.
  function automatic logic [XLEN-1:0] merge_write(
    input logic [XLEN-1:0] old,
    input logic [XLEN-1:0] wd,
    input lane_e           lane
  );
    logic [XLEN-1:0] r;
    r = old;
    case (lane)
      LN_Q:  r = wd;
      LN_D:  r = {{(XLEN-DW_W){1'b0}}, wd[DW_W-1:0]};
      LN_W:  r[WD_W-1:0] = wd[WD_W-1:0];
      LN_BL: r[BY_W-1:0] = wd[BY_W-1:0];
      LN_BH: r[2*BY_W-1:BY_W] = wd[BY_W-1:0];
      default: r = old;
    endcase
    return r;
  endfunction

  // Selected view of a register, zero-extended.
  function automatic logic [XLEN-1:0] view_read(
    input logic [XLEN-1:0] val,
    input lane_e           lane
  );
    logic [XLEN-1:0] r;
    r = '0;
    case (lane)
      LN_Q:  r = val;
      LN_D:  r[DW_W-1:0] = val[DW_W-1:0];
      LN_W:  r[WD_W-1:0] = val[WD_W-1:0];
      LN_BL: r[BY_W-1:0] = val[BY_W-1:0];
      LN_BH: r[BY_W-1:0] = val[2*BY_W-1:BY_W];
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rf_operand_decode.sv
`timescale 1ns/1ps
module rf_operand_decode
  import arf_pkg::*;
(
  input  logic [BASE_W-1:0] base,
  input  logic              ext,
  input  logic              pfx,
  input  logic [1:0]        size,
  output operand_t          op
);
  assign op = decode_operand(base, ext, pfx, size);
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
  import arf_pkg::*;
(
  input  logic [NREG*XLEN-1:0] regs_flat,
  input  operand_t             op,
  output logic [XLEN-1:0]      data
);
  logic [XLEN-1:0] picked;
  assign picked = regs_flat[op.idx*XLEN +: XLEN];
  assign data   = view_read(picked, op.lane);
endmodule

// File: rtl/rf_pc_reg.sv
`timescale 1ns/1ps
module rf_pc_reg
  import arf_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VEC = 64'hFFFF_FFFF_FFFF_FFF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            narrow,
  input  logic [XLEN-1:0] next,
  output logic [XLEN-1:0] q
);
  logic [XLEN-1:0] load_val;
  assign load_val = narrow ? merge_write(q, next, LN_D) : next;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RESET_VEC;
    else if (we) q <= load_val;
  end
endmodule

// File: rtl/aliased_regfile.sv
`timescale 1ns/1ps
module aliased_regfile
  import arf_pkg::*;
#(
  parameter logic [63:0] RESET_VEC = 64'hFFFF_FFFF_FFFF_FFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  rd0_base,
  input  logic        rd0_ext,
  input  logic        rd0_pfx,
  input  logic [1:0]  rd0_size,
  output logic [63:0] rd0_data,
  input  logic [2:0]  rd1_base,
  input  logic        rd1_ext,
  input  logic        rd1_pfx,
  input  logic [1:0]  rd1_size,
  output logic [63:0] rd1_data,
  input  logic        wr_en,
  input  logic [2:0]  wr_base,
  input  logic        wr_ext,
  input  logic        wr_pfx,
  input  logic [1:0]  wr_size,
  input  logic [63:0] wr_data,
  input  logic        pc_we,
  input  logic        pc_narrow,
  input  logic [63:0] pc_next,
  output logic [63:0] pc_q,
  output logic [31:0] pc_lo
);
  // Write side decode and one-hot hit vector.
  operand_t            wr_op;
  logic [NREG-1:0]     wr_hit;
  logic [NREG*XLEN-1:0] regs_flat;

  rf_operand_decode u_wdec (
    .base(wr_base), .ext(wr_ext), .pfx(wr_pfx), .size(wr_size), .op(wr_op)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] q;
    assign wr_hit[i] = wr_en && (wr_op.idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)         q <= '0;
      else if (wr_hit[i]) q <= merge_write(q, wr_data, wr_op.lane);
    end
    assign regs_flat[i*XLEN +: XLEN] = q;
  end

  // Read ports gathered into arrays so that one generate covers them.
  logic [BASE_W-1:0] rd_base_a [NRD];
  logic              rd_ext_a  [NRD];
  logic              rd_pfx_a  [NRD];
  logic [1:0]        rd_size_a [NRD];
  logic [XLEN-1:0]   rd_data_a [NRD];
  operand_t          rd_op_a   [NRD];

  assign rd_base_a[0] = rd0_base;
  assign rd_ext_a[0]  = rd0_ext;
  assign rd_pfx_a[0]  = rd0_pfx;
  assign rd_size_a[0] = rd0_size;
  assign rd_base_a[1] = rd1_base;
  assign rd_ext_a[1]  = rd1_ext;
  assign rd_pfx_a[1]  = rd1_pfx;
  assign rd_size_a[1] = rd1_size;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_operand_decode u_rdec (
      .base(rd_base_a[p]), .ext(rd_ext_a[p]), .pfx(rd_pfx_a[p]),
      .size(rd_size_a[p]), .op(rd_op_a[p])
    );
    rf_read_port u_port (
      .regs_flat(regs_flat), .op(rd_op_a[p]), .data(rd_data_a[p])
    );
  end

  assign rd0_data = rd_data_a[0];
  assign rd1_data = rd_data_a[1];

  rf_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst_n(rst_n), .we(pc_we), .narrow(pc_narrow),
    .next(pc_next), .q(pc_q)
  );
  assign pc_lo = pc_q[DW_W-1:0];
endmodule

// File: rtl/arf_chk.sv
`timescale 1ns/1ps
module arf_chk
  import arf_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [NREG-1:0]      wr_hit,
  input lane_e                wr_lane,
  input logic [NREG*XLEN-1:0] regs_flat,
  input logic [1:0]           rd0_size,
  input logic [63:0]          rd0_data,
  input logic [1:0]           rd1_size,
  input logic [63:0]          rd1_data,
  input logic                 pc_we,
  input logic                 pc_narrow,
  input logic [63:0]          pc_q,
  input logic [31:0]          pc_lo
);
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(wr_hit) == 1);
  a_r2_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> wr_hit == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_r
    a_r5_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(regs_flat[i*XLEN +: XLEN]));
    a_r4_dword_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && wr_lane == LN_D) |=> regs_flat[i*XLEN+DW_W +: DW_W] == '0);
    a_r5_narrow_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && (wr_lane == LN_W || wr_lane == LN_BL || wr_lane == LN_BH))
      |=> regs_flat[i*XLEN+WD_W +: XLEN-WD_W] == $past(regs_flat[i*XLEN+WD_W +: XLEN-WD_W]));
  end

  a_r3_rd0_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size == 2'd1 |-> rd0_data[63:32] == '0) and
    (rd0_size == 2'd2 |-> rd0_data[63:16] == '0) and
    (rd0_size == 2'd3 |-> rd0_data[63:8]  == '0));
  a_r9_rd1_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_size == 2'd1 |-> rd1_data[63:32] == '0) and
    (rd1_size == 2'd2 |-> rd1_data[63:16] == '0) and
    (rd1_size == 2'd3 |-> rd1_data[63:8]  == '0));

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));
  a_r10_pc_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_narrow) |=> pc_q[63:32] == '0);
  a_r10_pc_low_view: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pc_q) |-> $stable(pc_lo));
endmodule

bind aliased_regfile arf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hit(wr_hit),
  .wr_lane(wr_op.lane), .regs_flat(regs_flat),
  .rd0_size(rd0_size), .rd0_data(rd0_data),
  .rd1_size(rd1_size), .rd1_data(rd1_data),
  .pc_we(pc_we), .pc_narrow(pc_narrow), .pc_q(pc_q), .pc_lo(pc_lo)
);

// File: tb/aliased_regfile_tb.sv
`timescale 1ns/1ps
module aliased_regfile_tb;
  localparam logic [63:0] RV = 64'h0000_7FFF_0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd0_base = '0, rd1_base = '0, wr_base = '0;
  logic        rd0_ext = 0, rd0_pfx = 0, rd1_ext = 0, rd1_pfx = 0;
  logic        wr_ext = 0, wr_pfx = 0, wr_en = 0;
  logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
  logic [63:0] wr_data = '0, pc_next = '0;
  logic        pc_we = 0, pc_narrow = 0;
  logic [63:0] rd0_data, rd1_data, pc_q;
  logic [31:0] pc_lo;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_reg [16];
  logic [63:0] m_pc;

  always #4 clk = ~clk;

  aliased_regfile #(.RESET_VEC(RV)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_base(rd0_base), .rd0_ext(rd0_ext), .rd0_pfx(rd0_pfx), .rd0_size(rd0_size), .rd0_data(rd0_data),
    .rd1_base(rd1_base), .rd1_ext(rd1_ext), .rd1_pfx(rd1_pfx), .rd1_size(rd1_size), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_base(wr_base), .wr_ext(wr_ext), .wr_pfx(wr_pfx), .wr_size(wr_size), .wr_data(wr_data),
    .pc_we(pc_we), .pc_narrow(pc_narrow), .pc_next(pc_next), .pc_q(pc_q), .pc_lo(pc_lo)
  );

  // Reference: register number and bit offset of the addressed field.
  function automatic int ref_num(input logic [2:0] b, input logic e, input logic p, input logic [1:0] s);
    if (s == 2'd3 && !p && b >= 3'd4) return int'(b) - 4;
    return (p && e) ? int'(b) + 8 : int'(b);
  endfunction
  function automatic int ref_shift(input logic [2:0] b, input logic p, input logic [1:0] s);
    return (s == 2'd3 && !p && b >= 3'd4) ? 8 : 0;
  endfunction
  function automatic logic [63:0] ref_mask(input logic [1:0] s);
    case (s)
      2'd0: return '1;
      2'd1: return 64'h0000_0000_FFFF_FFFF;
      2'd2: return 64'h0000_0000_0000_FFFF;
      default: return 64'h0000_0000_0000_00FF;
    endcase
  endfunction
  function automatic logic [63:0] ref_read(input logic [2:0] b, input logic e, input logic p, input logic [1:0] s);
    return (m_reg[ref_num(b, e, p, s)] >> ref_shift(b, p, s)) & ref_mask(s);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: compare before the edge, then advance the model.
  task automatic step(input string tag);
    int n, sh;
    logic [63:0] mk;
    #2;
    chk({tag, " rd0"}, rd0_data, ref_read(rd0_base, rd0_ext, rd0_pfx, rd0_size));
    chk({tag, " rd1"}, rd1_data, ref_read(rd1_base, rd1_ext, rd1_pfx, rd1_size));
    chk({tag, " pc"}, pc_q, m_pc);
    chk({tag, " pc_lo"}, {32'h0, pc_lo}, {32'h0, m_pc[31:0]});
    @(posedge clk);
    if (wr_en) begin
      n  = ref_num(wr_base, wr_ext, wr_pfx, wr_size);
      sh = ref_shift(wr_base, wr_pfx, wr_size);
      mk = ref_mask(wr_size);
      if (wr_size == 2'd1) m_reg[n] = wr_data & mk;
      else m_reg[n] = (m_reg[n] & ~(mk << sh)) | ((wr_data & mk) << sh);
    end
    if (pc_we) m_pc = pc_narrow ? (pc_next & 64'h0000_0000_FFFF_FFFF) : pc_next;
    @(negedge clk);
  endtask

  task automatic rd(input int port, input int num, input logic [1:0] s);
    if (port == 0) begin
      rd0_base = 3'(num & 7); rd0_ext = num[3]; rd0_pfx = 1; rd0_size = s;
    end else begin
      rd1_base = 3'(num & 7); rd1_ext = num[3]; rd1_pfx = 1; rd1_size = s;
    end
  endtask

  task automatic wr(input logic [2:0] b, input logic e, input logic p, input logic [1:0] s, input logic [63:0] d);
    wr_en = 1; wr_base = b; wr_ext = e; wr_pfx = p; wr_size = s; wr_data = d;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_pc = RV;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset contents of every register and the program counter
    for (int i = 0; i < 8; i++) begin
      rd(0, 2*i, 2'd0); rd(1, 2*i+1, 2'd0);
      step("R1 reset");
    end

    // R9: fill all registers, both ports read different ones
    for (int i = 0; i < 16; i++) begin
      wr(3'(i & 7), i[3], 1'b1, 2'd0, {8{8'(8'h11 * (i + 1))}} ^ 64'h0123_4567_89AB_CDEF);
      rd(0, (i + 15) % 16, 2'd0); rd(1, (i + 7) % 16, 2'd1);
      step("R9 fill");
    end
    wr_en = 0;

    // R4: 32-bit write zero-extends
    wr(3'd3, 1'b0, 1'b0, 2'd1, 64'hDEAD_BEEF_CAFE_F00D);
    rd(0, 3, 2'd0); rd(1, 3, 2'd2);
    step("R4 dword write");
    wr_en = 0;
    step("R4 dword readback");

    // R5: word and byte writes keep surrounding bits
    wr(3'd5, 1'b0, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_1234);
    rd(0, 5, 2'd0); rd(1, 9, 2'd0);
    step("R5 word write");
    wr(3'd1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_0000_00A5);
    step("R5 byte write");
    wr_en = 0;
    step("R5 readback");

    // R6: byte code 4 without prefix is bits 15:8 of register 0
    wr(3'd4, 1'b0, 1'b0, 2'd3, 64'h0000_0000_0000_007E);
    rd(0, 0, 2'd0); rd(1, 4, 2'd0);
    step("R6 high byte write");
    wr_en = 0;
    rd0_base = 3'd4; rd0_ext = 0; rd0_pfx = 0; rd0_size = 2'd3;
    rd1_base = 3'd7; rd1_ext = 0; rd1_pfx = 0; rd1_size = 2'd3;
    step("R6 high byte read");
    rd0_base = 3'd2; rd0_pfx = 0;
    step("R6 low byte read");

    // R7: byte code 4 with prefix is the low byte of register 4
    wr(3'd4, 1'b0, 1'b1, 2'd3, 64'h0000_0000_0000_00C3);
    rd(0, 4, 2'd0); rd(1, 0, 2'd0);
    step("R7 prefixed byte write");
    wr_en = 0;
    rd0_base = 3'd4; rd0_ext = 0; rd0_pfx = 1; rd0_size = 2'd3;
    rd1_base = 3'd6; rd1_ext = 1; rd1_pfx = 1; rd1_size = 2'd3;
    step("R7 prefixed byte read");

    // R2: ext without prefix is ignored on write and read
    wr(3'd2, 1'b1, 1'b0, 2'd0, 64'h5555_AAAA_5555_AAAA);
    rd(0, 2, 2'd0); rd(1, 10, 2'd0);
    step("R2 ext ignored write");
    wr_en = 0;
    rd1_base = 3'd2; rd1_ext = 1; rd1_pfx = 0;
    step("R2 ext ignored read");

    // R8: same-cycle read of the written register sees the old value
    wr(3'd6, 1'b0, 1'b1, 2'd0, 64'h0F0F_0F0F_F0F0_F0F0);
    rd(0, 6, 2'd0); rd(1, 6, 2'd2);
    step("R8 no bypass");
    wr_en = 0;
    step("R8 after edge");

    // R10: program counter loads, narrow load, hold
    pc_we = 1; pc_narrow = 0; pc_next = 64'h8000_0001_2345_6789;
    step("R10 pc wide load");
    pc_narrow = 1; pc_next = 64'hFFFF_FFFF_8765_4321;
    step("R10 pc narrow load");
    pc_we = 0; pc_next = 64'h1;
    step("R10 pc hold");
    step("R10 pc hold 2");

    // R3: mixed traffic over all sizes, prefixes and registers
    for (int k = 0; k < 400; k++) begin
      wr_en = $urandom_range(0, 1); wr_base = 3'($urandom); wr_ext = 1'($urandom);
      wr_pfx = 1'($urandom); wr_size = 2'($urandom); wr_data = {$urandom, $urandom};
      rd0_base = 3'($urandom); rd0_ext = 1'($urandom); rd0_pfx = 1'($urandom); rd0_size = 2'($urandom);
      rd1_base = 3'($urandom); rd1_ext = 1'($urandom); rd1_pfx = 1'($urandom); rd1_size = 2'($urandom);
      pc_we = 1'($urandom_range(0, 3) == 0); pc_narrow = 1'($urandom); pc_next = {$urandom, $urandom};
      step("R3 mixed");
    end
    wr_en = 0; pc_we = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule